// File: doc/BRIEF.md
# Epoch-Tagged Fetch Redirect Controller

This block is the control core of a two-stage pipeline in which instruction fetch and execution run apart, linked only by two queues. The fetch side owns the program counter and a one-bit fetch epoch. Each cycle it reads a word from a combinational instruction port. It guesses that the next address is the current one plus four. It pushes a record into a fetch-to-execute queue, holding the address, the guessed successor, the instruction word and the fetch epoch.

The execute side owns its own one-bit epoch. For the record at the head of the queue, an outside resolver supplies the true next address. A record whose epoch differs from the execute epoch is wrong-path work: it is consumed and dropped. A kept record retires. When its true successor differs from the guess, execute places the true address in a one-entry redirect queue and sets its epoch to the inverse of the record's epoch. Fetch sees the redirect on the next cycle. It then loads the new address, flips its own epoch, pops the redirect and fetches nothing in that cycle. No queue is ever flushed: stale records drain one at a time through the epoch test.

Top module: `epoch_redirect_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `imem_addr` equals the parameter RESET_PC, `retire_valid` is 0 and `ex_head_valid` is 0.
- R2: The queue head presents `ex_head_pc`, `ex_head_ppc` equal to `ex_head_pc + 4`, and `ex_head_inst` equal to the word that `imem_data` carried when that address was fetched.
- R3: With no redirect pending and room in the fetch-to-execute queue, `imem_addr` advances by 4 every cycle and stays word-aligned.
- R4: When the fetch-to-execute queue (QDEPTH entries) is full, `imem_addr` holds its value and no record is fetched.
- R5: A retire whose resolved next address differs from `ex_head_ppc` causes `imem_addr` to equal that resolved address two cycles after the retire strobe.
- R6: A kept record whose resolved next address equals `ex_head_ppc` retires with no redirect, and the next retired pc is `ex_head_pc + 4`.
- R7: After a mispredicting retire, every record fetched before the redirect is dropped without a retire strobe; the next retired pc is the resolved address.
- R8: While `ex_enable` is 0 nothing is consumed from the queue and `retire_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Fetch address to the instruction port |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| ex_enable | input | 1 | Execute may consume the head record this cycle |
| ex_resolved_pc | input | 32 | True next address of the head record |
| ex_head_valid | output | 1 | Queue holds a record for execute |
| ex_head_pc | output | 32 | Address of the head record |
| ex_head_ppc | output | 32 | Guessed successor of the head record |
| ex_head_inst | output | 32 | Instruction word of the head record |
| retire_valid | output | 1 | A kept record is consumed this cycle |
| retire_pc | output | 32 | Address of the retired record |

## Verification
The assertions assume that `ex_resolved_pc` is word-aligned and that it is a pure function of the head record, valid in the same cycle. They also assume `imem_data` answers the current `imem_addr` without delay. The bench keeps to this. It derives both inputs combinationally from the block's own outputs, through a small branch table and a fixed address-to-word mapping, and every table target is a multiple of four. `ex_enable` is changed only on the falling edge, so the stall cycles never race the execute decision.

// File: rtl/erc_pkg.sv
package erc_pkg;
    localparam int XLEN   = 32;
    localparam int INST_W = 32;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   ppc;
        logic [INST_W-1:0] inst;
        logic              epoch;
    } f2e_rec_t;
endpackage

// File: rtl/erc_queue.sv
module erc_queue #(
    parameter int  DEPTH = 2,
    parameter type T     = logic
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enq,
    input  T     enq_data,
    input  logic deq,
    output T     head,
    output logic not_empty,
    output logic not_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int SLOTS = 2 ** PW;

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t st_q, st_d;
    T        mem_q [SLOTS];
    logic    do_enq, do_deq;

    assign not_empty = (st_q.cnt != '0);
    assign not_full  = (st_q.cnt != CW'(DEPTH));
    assign do_enq    = enq && not_full;
    assign do_deq    = deq && not_empty;
    assign head      = mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (do_enq) begin
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + PW'(1);
        end
        if (do_deq) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + PW'(1);
        end
        if (do_enq && !do_deq) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (do_deq && !do_enq) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_enq) begin
            mem_q[st_q.wr] <= enq_data;
        end
    end
endmodule

// File: rtl/erc_fetch.sv
module erc_fetch
    import erc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [INST_W-1:0] imem_data,
    input  logic              redir_valid,
    input  logic [XLEN-1:0]   redir_pc,
    output logic              redir_pop,
    input  logic              q_ready,
    output logic              q_push,
    output f2e_rec_t          q_rec
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            epoch;
    } fstate_t;

    fstate_t st_q, st_d;

    assign imem_addr = st_q.pc;

    always_comb begin
        st_d      = st_q;
        redir_pop = 1'b0;
        q_push    = 1'b0;
        q_rec     = '{pc: st_q.pc, ppc: st_q.pc + STEP, inst: imem_data, epoch: st_q.epoch};
        if (redir_valid) begin
            st_d.pc    = redir_pc;
            st_d.epoch = ~st_q.epoch;
            redir_pop  = 1'b1;
        end else if (q_ready) begin
            st_d.pc = st_q.pc + STEP;
            q_push  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pc: RESET_PC, epoch: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/erc_execute.sv
module erc_execute
    import erc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            head_valid,
    input  f2e_rec_t        head,
    input  logic [XLEN-1:0] resolved_pc,
    output logic            pop,
    input  logic            redir_ready,
    output logic            redir_push,
    output logic [XLEN-1:0] redir_pc,
    output logic            retire_valid,
    output logic [XLEN-1:0] retire_pc,
    output logic            epoch_o
);
    typedef struct packed {
        logic epoch;
    } estate_t;

    estate_t st_q, st_d;
    logic    same_epoch, wrong_guess;

    assign same_epoch = (head.epoch == st_q.epoch);
    assign wrong_guess = (resolved_pc != head.ppc);
    assign redir_pc    = resolved_pc;
    assign retire_pc   = head.pc;
    assign epoch_o     = st_q.epoch;

    always_comb begin
        st_d         = st_q;
        pop          = 1'b0;
        redir_push   = 1'b0;
        retire_valid = 1'b0;
        if (go && head_valid) begin
            if (!same_epoch) begin
                pop = 1'b1;
            end else if (!wrong_guess) begin
                pop          = 1'b1;
                retire_valid = 1'b1;
            end else if (redir_ready) begin
                pop          = 1'b1;
                retire_valid = 1'b1;
                redir_push   = 1'b1;
                st_d.epoch   = ~head.epoch;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{epoch: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/epoch_redirect_ctrl.sv
module epoch_redirect_ctrl
    import erc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100,
    parameter int              QDEPTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [INST_W-1:0] imem_data,
    input  logic              ex_enable,
    input  logic [XLEN-1:0]   ex_resolved_pc,
    output logic              ex_head_valid,
    output logic [XLEN-1:0]   ex_head_pc,
    output logic [XLEN-1:0]   ex_head_ppc,
    output logic [INST_W-1:0] ex_head_inst,
    output logic              retire_valid,
    output logic [XLEN-1:0]   retire_pc
);
    localparam int REDIR_DEPTH = 1;

    f2e_rec_t        f2e_in, f2e_head;
    logic            f2e_push, f2e_pop, f2e_not_empty, f2e_not_full;
    logic [XLEN-1:0] redir_in, redir_head;
    logic            redir_push, redir_pop, redir_valid, redir_not_full;
    logic            ex_epoch;

    erc_fetch #(.RESET_PC(RESET_PC)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .redir_valid(redir_valid),
        .redir_pc   (redir_head),
        .redir_pop  (redir_pop),
        .q_ready    (f2e_not_full),
        .q_push     (f2e_push),
        .q_rec      (f2e_in)
    );

    erc_queue #(.DEPTH(QDEPTH), .T(f2e_rec_t)) u_f2e (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq      (f2e_push),
        .enq_data (f2e_in),
        .deq      (f2e_pop),
        .head     (f2e_head),
        .not_empty(f2e_not_empty),
        .not_full (f2e_not_full)
    );

    erc_execute u_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (ex_enable),
        .head_valid  (f2e_not_empty),
        .head        (f2e_head),
        .resolved_pc (ex_resolved_pc),
        .pop         (f2e_pop),
        .redir_ready (redir_not_full),
        .redir_push  (redir_push),
        .redir_pc    (redir_in),
        .retire_valid(retire_valid),
        .retire_pc   (retire_pc),
        .epoch_o     (ex_epoch)
    );

    erc_queue #(.DEPTH(REDIR_DEPTH), .T(logic [XLEN-1:0])) u_redir (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq      (redir_push),
        .enq_data (redir_in),
        .deq      (redir_pop),
        .head     (redir_head),
        .not_empty(redir_valid),
        .not_full (redir_not_full)
    );

    assign ex_head_valid = f2e_not_empty;
    assign ex_head_pc    = f2e_head.pc;
    assign ex_head_ppc   = f2e_head.ppc;
    assign ex_head_inst  = f2e_head.inst;
endmodule

// File: rtl/erc_checker.sv
module erc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ex_enable,
    input logic [31:0] imem_addr,
    input logic        redir_valid,
    input logic [31:0] redir_pc,
    input logic        f2e_not_full,
    input logic        f2e_pop,
    input logic        head_valid,
    input logic [31:0] head_pc,
    input logic [31:0] head_ppc,
    input logic        head_epoch,
    input logic        ex_epoch,
    input logic        retire_valid
);
    p_ppc_guess_r2: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |-> head_ppc == head_pc + 32'd4);

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (f2e_not_full && !redir_valid) |=> imem_addr == $past(imem_addr) + 32'd4);

    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00);

    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!f2e_not_full && !redir_valid) |=> imem_addr == $past(imem_addr));

    p_redirect_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> imem_addr == $past(redir_pc));

    p_kept_epoch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> head_epoch == ex_epoch);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_enable |-> (!retire_valid && !f2e_pop));
endmodule

bind epoch_redirect_ctrl erc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_enable   (ex_enable),
    .imem_addr   (imem_addr),
    .redir_valid (redir_valid),
    .redir_pc    (redir_head),
    .f2e_not_full(f2e_not_full),
    .f2e_pop     (f2e_pop),
    .head_valid  (f2e_not_empty),
    .head_pc     (f2e_head.pc),
    .head_ppc    (f2e_head.ppc),
    .head_epoch  (f2e_head.epoch),
    .ex_epoch    (ex_epoch),
    .retire_valid(retire_valid)
);

// File: tb/epoch_redirect_ctrl_test.sv
module epoch_redirect_ctrl_test;
    localparam logic [31:0] RST_PC = 32'h0000_0100;
    localparam int          QD     = 2;
    localparam int          NBR    = 6;
    localparam int          WALK_RETIRES = 80;

    // branch table: {pc, true successor}
    localparam logic [63:0] BR_TAB [NBR] = '{
        {32'h0000_010C, 32'h0000_0200},
        {32'h0000_0204, 32'h0000_0208},
        {32'h0000_020C, 32'h0000_0300},
        {32'h0000_0300, 32'h0000_0180},
        {32'h0000_018C, 32'h0000_0400},
        {32'h0000_0410, 32'h0000_0100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_enable = 1'b0;
    logic [31:0] imem_addr, imem_data, ex_resolved_pc;
    logic        ex_head_valid, retire_valid;
    logic [31:0] ex_head_pc, ex_head_ppc, ex_head_inst, retire_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return ~a;
    endfunction

    function automatic logic [31:0] true_next(input logic [31:0] a);
        logic [31:0] n;
        n = a + 32'd4;
        for (int i = 0; i < NBR; i++) begin
            if (BR_TAB[i][63:32] == a) n = BR_TAB[i][31:0];
        end
        return n;
    endfunction

    assign imem_data      = word_at(imem_addr);
    assign ex_resolved_pc = true_next(ex_head_pc);

    epoch_redirect_ctrl #(.RESET_PC(RST_PC), .QDEPTH(QD)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .imem_addr     (imem_addr),
        .imem_data     (imem_data),
        .ex_enable     (ex_enable),
        .ex_resolved_pc(ex_resolved_pc),
        .ex_head_valid (ex_head_valid),
        .ex_head_pc    (ex_head_pc),
        .ex_head_ppc   (ex_head_ppc),
        .ex_head_inst  (ex_head_inst),
        .retire_valid  (retire_valid),
        .retire_pc     (retire_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 addr in reset", imem_addr, RST_PC);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pc;
        logic [31:0] redir_tgt;
        logic [31:0] held;
        int          due;
        int          retired;
        bool_t_dummy: begin end

        // reset state and sequential fetch, R1 and R3
        ex_enable = 1'b1;
        do_reset();
        check("R1 addr after reset", imem_addr, RST_PC);
        check("R1 no retire", {31'd0, retire_valid}, 32'd0);
        check("R1 queue empty", {31'd0, ex_head_valid}, 32'd0);
        next_cycle();
        check("R3 step 1", imem_addr, RST_PC + 32'd4);
        next_cycle();
        check("R3 step 2", imem_addr, RST_PC + 32'd8);
        check("R6 first retire", retire_pc, RST_PC + 32'd4);

        // full queue stall, R4 and R8
        ex_enable = 1'b0;
        do_reset();
        for (int c = 0; c < 5; c++) begin
            check("R8 no retire while idle", {31'd0, retire_valid}, 32'd0);
            if (c == 3) held = imem_addr;
            if (c == 4) check("R4 fetch holds when full", imem_addr, held);
            next_cycle();
        end
        check("R4 held address", imem_addr, RST_PC + 32'(4 * QD));
        check("R2 head pc after stall", ex_head_pc, RST_PC);
        check("R2 head inst after stall", ex_head_inst, word_at(RST_PC));

        // table walk: architectural path, R2 R5 R6 R7 R8
        do_reset();
        exp_pc  = RST_PC;
        due     = 0;
        retired = 0;
        redir_tgt = '0;
        for (int cyc = 0; cyc < 2000 && retired < WALK_RETIRES; cyc++) begin
            if (cyc != 0) begin
                @(negedge clk);
                ex_enable = !((cyc % 7 == 3) || (cyc % 11 == 5));
                #1;
            end else begin
                ex_enable = 1'b1;
                #1;
            end
            if (due > 0) begin
                due--;
                if (due == 0) check("R5 fetch redirected", imem_addr, redir_tgt);
            end
            if (!ex_enable) begin
                check("R8 idle cycle", {31'd0, retire_valid}, 32'd0);
            end else if (retire_valid) begin
                retired++;
                check("R7 path order", retire_pc, exp_pc);
                check("R2 guessed successor", ex_head_ppc, retire_pc + 32'd4);
                check("R2 instruction word", ex_head_inst, word_at(retire_pc));
                if (true_next(retire_pc) != retire_pc + 32'd4) begin
                    redir_tgt = true_next(retire_pc);
                    due = 2;
                end
                exp_pc = true_next(retire_pc);
            end
        end
        check("R6 walk completed", 32'(retired), 32'(WALK_RETIRES));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule